// File: doc/BRIEF.md
# Multiplexer Local Select Decoder

This combinational block converts a binary select address into a one-hot select word. The word drives the configuration select lines of one branch of a multi-level routing multiplexer. A second output carries the bit-wise complement of the same word, for select switches that need both polarities. Every address value produces exactly one asserted select line, so the branch never sees an empty or a doubled selection.

The data width is a parameter. By default the address width is the smallest width that can name every output, which is one bit for data widths of 1 and 2. A wider address may be requested. In that case every address value at or above the data width falls back to the highest select line. A one-line instance does not decode at all: its single select bit follows the single address bit. The block holds no state, so its outputs follow the address within the same cycle.

Top module: `msel_dec`

## Requirements
- R1: For a data width of 2 or more, an address value k below the data width sets select bit k (bit 0 is the least significant) and clears every other select bit.
- R2: For a data width of 2 or more, an address value at or above the data width sets only the most significant select bit, at position data width minus 1.
- R3: For a data width of 2 or more, the select word has exactly one bit set for every address value.
- R4: With a data width of 1, the select output equals address bit 0 and the inverted output is its complement.
- R5: The inverted output is always the bit-wise complement of the select output.
- R6: The default address width is ceil(log2(data width)), with a minimum of 1. An address width below that value, a data width below 1, or an address width other than 1 with a data width of 1 stops elaboration.
- R7: The outputs are purely combinational. A change of address is visible on both outputs before the next clock edge, and the block holds no registers.
- R8: An address wider than the minimum is compared over its full width, so high address bits that exceed the data width send the decoder to the fallback of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | ADDR_W | Binary select address |
| sel_o | output | DATA_W | One-hot select word |
| sel_n_o | output | DATA_W | Bit-wise complement of sel_o |

## Verification
The bench sweeps every address of instances with data widths 1, 2, 5 and 8, and of a five-line instance with a four-bit address. This covers both the fallback codes and the high address bits. A design that gives all zeros, or wraps the index modulo the width, for an out-of-range address fails the fallback checks on addresses 5 to 15. A design that decodes the one-bit case as a one-hot word of address 0 inverts the pass-through and fails on both codes. The inverted output comes from logic separate from the select word, so a slip in either path shows up as a mismatch in the complement check. A further check changes the address between clock edges and confirms that the outputs follow without waiting for a clock.

// File: rtl/msel_pkg.sv
package msel_pkg;

   // Smallest address width that names every select line (never below 1).
   function automatic int min_addr_w(input int data_w);
      int w;
      w = 1;
      while ((1 << w) < data_w) w++;
      return w;
   endfunction

   // Decoder variant chosen at elaboration.
   typedef enum logic [0:0] {
      VAR_PASS = 1'b0,
      VAR_TREE = 1'b1
   } msel_variant_e;

   function automatic msel_variant_e pick_variant(input int data_w);
      return (data_w == 1) ? VAR_PASS : VAR_TREE;
   endfunction

endpackage

// File: rtl/msel_pass1.sv
module msel_pass1 (
   input  logic addr_i,
   output logic sel_o,
   output logic sel_n_o
);

   assign sel_o   = addr_i;
   assign sel_n_o = !addr_i;

   always_comb begin
      if (!$isunknown(addr_i)) begin
         // R4
         pass_polarity_chk: assert (sel_o != sel_n_o)
            else $error("single-line select and its complement agree");
      end
   end

endmodule

// File: rtl/msel_onehot_core.sv
module msel_onehot_core #(
   parameter int DATA_W = 5,
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [DATA_W-1:0] sel_o
);

   localparam int              TOP_IDX  = DATA_W - 1;
   localparam logic [ADDR_W-1:0] TOP_CODE = ADDR_W'(TOP_IDX);

   // Lines below the top match one exact code each.
   for (genvar k = 0; k < TOP_IDX; k++) begin : g_low
      assign sel_o[k] = (addr_i == ADDR_W'(k));
   end

   // The top line absorbs its own code and every code beyond the range.
   assign sel_o[TOP_IDX] = (addr_i >= TOP_CODE);

   always_comb begin
      if (!$isunknown(addr_i)) begin
         // R3
         sel_onehot_chk: assert ($onehot(sel_o))
            else $error("select word not one-hot");
         // R1
         sel_in_range_chk: assert ((int'(addr_i) >= DATA_W) || sel_o[int'(addr_i)])
            else $error("addressed select line not set");
         // R2
         sel_fallback_chk: assert ((int'(addr_i) < DATA_W) || sel_o[TOP_IDX])
            else $error("out-of-range code missed the top line");
      end
   end

endmodule

// File: rtl/msel_inv_core.sv
module msel_inv_core #(
   parameter int DATA_W = 5,
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [DATA_W-1:0] sel_n_o
);

   localparam int              TOP_IDX  = DATA_W - 1;
   localparam logic [ADDR_W-1:0] TOP_CODE = ADDR_W'(TOP_IDX);

   // Active-low lines decoded from the address directly, not by inverting
   // the one-hot word, so both polarities have their own short path.
   for (genvar k = 0; k < TOP_IDX; k++) begin : g_low
      assign sel_n_o[k] = (addr_i != ADDR_W'(k));
   end

   assign sel_n_o[TOP_IDX] = (addr_i < TOP_CODE);

   always_comb begin
      if (!$isunknown(addr_i)) begin
         // R3
         inv_one_low_chk: assert ($countones(~sel_n_o) == 1)
            else $error("inverted word does not hold exactly one low bit");
      end
   end

endmodule

// File: rtl/msel_dec.sv
module msel_dec #(
   parameter int DATA_W = 5,
   parameter int ADDR_W = msel_pkg::min_addr_w(DATA_W)
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [DATA_W-1:0] sel_o,
   output logic [DATA_W-1:0] sel_n_o
);

   import msel_pkg::*;

   localparam int            MIN_AW  = min_addr_w(DATA_W);
   localparam msel_variant_e VARIANT = pick_variant(DATA_W);

   // R6: elaboration-time parameter checks
   if (DATA_W < 1) begin : g_bad_data_w
      $error("msel_dec: DATA_W must be at least 1");
   end
   if (ADDR_W < MIN_AW) begin : g_bad_addr_w
      $error("msel_dec: ADDR_W too narrow for DATA_W");
   end
   if ((DATA_W == 1) && (ADDR_W != 1)) begin : g_bad_pass_w
      $error("msel_dec: single-line instance needs a one-bit address");
   end

   if (VARIANT == VAR_PASS) begin : g_pass
      msel_pass1 u_pass (
         .addr_i  (addr_i[0]),
         .sel_o   (sel_o[0]),
         .sel_n_o (sel_n_o[0])
      );
   end else begin : g_tree
      msel_onehot_core #(
         .DATA_W (DATA_W),
         .ADDR_W (ADDR_W)
      ) u_onehot (
         .addr_i (addr_i),
         .sel_o  (sel_o)
      );
      msel_inv_core #(
         .DATA_W (DATA_W),
         .ADDR_W (ADDR_W)
      ) u_inv (
         .addr_i  (addr_i),
         .sel_n_o (sel_n_o)
      );
   end

   always_comb begin
      if (!$isunknown(addr_i)) begin
         // R5
         polarity_pair_chk: assert (sel_n_o == ~sel_o)
            else $error("inverted output is not the complement of select");
      end
   end

endmodule

// File: tb/test_msel_dec.sv
module test_msel_dec;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [0:0] a1;  logic [0:0] d1, n1;
   logic [0:0] a2;  logic [1:0] d2, n2;
   logic [2:0] a5;  logic [4:0] d5, n5;
   logic [3:0] a5w; logic [4:0] d5w, n5w;
   logic [2:0] a8;  logic [7:0] d8, n8;

   msel_dec #(.DATA_W(1)) i_msel_dec_w1 (.addr_i(a1), .sel_o(d1), .sel_n_o(n1));
   msel_dec #(.DATA_W(2)) i_msel_dec_w2 (.addr_i(a2), .sel_o(d2), .sel_n_o(n2));
   msel_dec #(.DATA_W(5)) i_msel_dec    (.addr_i(a5), .sel_o(d5), .sel_n_o(n5));
   msel_dec #(.DATA_W(5), .ADDR_W(4)) i_msel_dec_wide (.addr_i(a5w), .sel_o(d5w), .sel_n_o(n5w));
   msel_dec #(.DATA_W(8)) i_msel_dec_w8 (.addr_i(a8), .sel_o(d8), .sel_n_o(n8));

   typedef struct {
      int          unit;
      int          dw;
      int          addr;
      logic [15:0] exp;
   } item_t;

   item_t sbq[$];

   // Expected select word from the requirements.
   function automatic logic [15:0] expect_sel(input int dw, input int a);
      int idx;
      if (dw == 1) return 16'(a & 1);          // R4
      idx = (a < dw) ? a : dw - 1;             // R1 / R2 / R8
      return 16'(1) << idx;
   endfunction

   function automatic logic [15:0] mask_of(input int dw);
      return (16'(1) << dw) - 16'(1);
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input int unit, input int dw, input int a);
      item_t it;
      @(posedge clk);
      case (unit)
         0: a1  = 1'(a);
         1: a2  = 1'(a);
         2: a5  = 3'(a);
         3: a5w = 4'(a);
         default: a8 = 3'(a);
      endcase
      it.unit = unit; it.dw = dw; it.addr = a; it.exp = expect_sel(dw, a);
      sbq.push_back(it);
   endtask

   // Monitor: compares away from the active edge.
   always @(negedge clk) begin
      if (sbq.size() > 0) begin
         item_t it;
         logic [15:0] ad, an;
         string rq;
         it = sbq.pop_front();
         case (it.unit)
            0: begin ad = 16'(d1);  an = 16'(n1);  end
            1: begin ad = 16'(d2);  an = 16'(n2);  end
            2: begin ad = 16'(d5);  an = 16'(n5);  end
            3: begin ad = 16'(d5w); an = 16'(n5w); end
            default: begin ad = 16'(d8); an = 16'(n8); end
         endcase
         if (it.dw == 1)            rq = "R4";
         else if (it.unit == 3 && it.addr >= 8) rq = "R8";
         else if (it.addr >= it.dw) rq = "R2";
         else                       rq = "R1";
         chk(rq, ad, it.exp);
         chk("R5", an, ~it.exp & mask_of(it.dw));
         if (it.dw > 1) chk("R3", 16'($countones(ad)), 16'(1));
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      a1 = '0; a2 = '0; a5 = '0; a5w = '0; a8 = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state: address 0 selects line 0 (R1)
      chk("R1", 16'(d5), 16'h0001);
      rst_n = 1'b1;

      // R6: default address widths
      chk("R6", 16'($bits(a1)), 16'(1));
      chk("R6", 16'($bits(i_msel_dec_w2.addr_i)), 16'(1));
      chk("R6", 16'($bits(i_msel_dec.addr_i)), 16'(3));
      chk("R6", 16'($bits(i_msel_dec_w8.addr_i)), 16'(3));

      for (int a = 0; a < 2;  a++) drive(0, 1, a);
      for (int a = 0; a < 2;  a++) drive(1, 2, a);
      for (int a = 0; a < 8;  a++) drive(2, 5, a);
      for (int a = 15; a >= 0; a--) drive(3, 5, a);
      for (int a = 0; a < 8;  a++) drive(4, 8, a);
      drive(2, 5, 6);
      drive(2, 5, 0);
      drive(0, 1, 1);
      drive(0, 1, 0);
      @(posedge clk);
      @(posedge clk);
      wait (sbq.size() == 0);

      // R7: outputs follow the address between edges
      @(negedge clk);
      a8 = 3'd3;
      #1;
      chk("R7", 16'(d8), 16'h0008);
      a5 = 3'd7;
      #1;
      chk("R7", 16'(d5), 16'h0010);
      chk("R7", 16'(n5), 16'h000F);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule